// File: doc/BRIEF.md
# Reloading Timer/Counter with Three Count Sources

A 16-bit up-counter behind a byte-wide register port. It compares its count with a reload value and restarts at 0001h on every match. The count can advance on three sources. The first is a power-of-two prescaled system clock, which gives a periodic timer. The second is qualifying edges on an external pin. The third is qualifying edges on a digital comparator result. In both edge-counting modes the prescaler is bypassed.

Every match is a time-out. On a time-out the timer output level flips and a single-cycle interrupt pulse is raised. While the timer is disabled, software can preload any starting count. That value governs only the first pass, because each later pass starts again from 0001h. One control bit does two jobs: it sets the idle level of the timer output, and it chooses whether rising or falling edges are counted. Both external inputs pass through a synchronizer before the edge detector sees them.

Top module: `mm_timer`

## Requirements
- R1: After reset the count reads 0001h, the reload value reads FFFFh, the control byte reads 00h, and `tmr_out_o` and `irq_o` are low.
- R2: Registers are addressed as follows: 0 is the count high byte, 1 the count low byte, 2 the reload high byte, 3 the reload low byte, and 4 the control byte. Any other address reads 00h. Control fields are bit 7 enable, bit 6 polarity, bits 5:3 prescale select, and bits 1:0 mode (00 periodic, 01 pin edges, 10 comparator edges, 11 periodic). Bit 2 reads 0. Reads of the count return its live value.
- R3: Writes to the count bytes load the count only while enable is 0. While the timer runs they are ignored.
- R4: In periodic mode the count advances once every 2^psel clocks. The prescaler is held clear while the timer is disabled, so the first advance comes 2^psel clocks after enable is written.
- R5: A time-out occurs when the count equals the reload value at an advance, and the count then becomes 0001h. Starting from count S, the first time-out comes (reload−S+1)·2^psel clocks after enabling. Each later time-out comes reload·2^psel clocks after the previous one.
- R6: While disabled, `tmr_out_o` takes the polarity bit. While enabled, it toggles on every time-out.
- R7: Each time-out produces exactly one high cycle of `irq_o`, in the same cycle that `tmr_out_o` changes.
- R8: In pin mode, each rising edge of `pin_i` (polarity 0) or each falling edge (polarity 1) adds exactly one to the count. `cmp_i` has no effect in this mode.
- R9: In comparator mode, edges of `cmp_i` are counted under the same polarity rule, and `pin_i` has no effect.
- R10: Inputs toggling as fast as every two clocks (a quarter of the clock rate) have every qualifying edge counted.
- R11: While disabled, the count holds unless written and no interrupt is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register address |
| wr_en_i | input | 1 | Write strobe for the addressed byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed byte |
| pin_i | input | 1 | External count input (asynchronous) |
| cmp_i | input | 1 | Comparator result count input (asynchronous) |
| tmr_out_o | output | 1 | Timer output level |
| irq_o | output | 1 | Time-out interrupt pulse |

## Verification
The hardest case to reach from the ports is the first pass that starts from a software-written count and then runs into the periodic restart at 0001h. The first time-out and the second one follow different formulas, and both depend on the prescaler having been cleared while the timer was disabled. Each table vector therefore disables the timer, preloads a start value and the polarity, enables it, and measures the clock count to the first interrupt and then to the second. A second difficult case is the quarter-rate edge limit. Directed pulses, two clocks high and two clocks low, drive one input while the other is pulsed alongside it, and the final count shows that no edge was lost and none was counted from the ignored input.

// File: rtl/mm_timer_pkg.sv
package mm_timer_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned PSEL_W = 3;
  localparam int unsigned PCNT_W = (1 << PSEL_W) - 1;

  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
  localparam logic [ADDR_W-1:0] A_RLD_HI = 3'd2;
  localparam logic [ADDR_W-1:0] A_RLD_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;

  typedef enum logic [1:0] {
    MODE_PERIODIC = 2'b00,
    MODE_PIN      = 2'b01,
    MODE_CMP      = 2'b10,
    MODE_PERIOD2  = 2'b11
  } mode_e;

  typedef struct packed {
    logic              en;
    logic              pol;
    logic [PSEL_W-1:0] psel;
    logic              rsvd;
    mode_e             mode;
  } ctrl_t;
endpackage

// File: rtl/mm_timer_presc.sv
module mm_timer_presc
  import mm_timer_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PSEL_W-1:0] sel_i,
  output logic              tick_o
);
  logic [PCNT_W-1:0] cnt_q;
  logic [PCNT_W-1:0] mask;

  assign mask   = ~({PCNT_W{1'b1}} << sel_i);
  assign tick_o = en_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mm_timer_edge.sv
module mm_timer_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[STAGES-1] & prev_q;
endmodule

// File: rtl/mm_timer.sv
module mm_timer
  import mm_timer_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter logic [15:0] RESET_RELOAD = 16'hFFFF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  input  logic              pin_i,
  input  logic              cmp_i,
  output logic              tmr_out_o,
  output logic              irq_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] reload_q;
  logic             out_q;
  logic             irq_q;

  logic       en, pol, edge_mode, cnt_wr;
  logic       tick, step, timeout;
  logic [1:0] src, rise, fall, sel_edge;

  assign en        = ctrl_q.en;
  assign pol       = ctrl_q.pol;
  assign edge_mode = en && (ctrl_q.mode == MODE_PIN || ctrl_q.mode == MODE_CMP);
  assign cnt_wr    = wr_en_i && (addr_i == A_CNT_HI || addr_i == A_CNT_LO);

  mm_timer_presc u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .sel_i  (ctrl_q.psel),
    .tick_o (tick)
  );

  // index 0: pin, index 1: comparator
  assign src = {cmp_i, pin_i};
  for (genvar g = 0; g < 2; g++) begin : g_edge
    mm_timer_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (src[g]),
      .rise_o (rise[g]),
      .fall_o (fall[g])
    );
  end
  assign sel_edge = pol ? fall : rise;

  always_comb begin
    unique case (ctrl_q.mode)
      MODE_PIN: step = en && sel_edge[0];
      MODE_CMP: step = en && sel_edge[1];
      default:  step = tick;
    endcase
  end
  assign timeout = step && (count_q == reload_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= '0;
      count_q  <= 16'h0001;
      reload_q <= RESET_RELOAD;
    end else begin
      if (wr_en_i) begin
        unique case (addr_i)
          A_RLD_HI: reload_q[15:8] <= wdata_i;
          A_RLD_LO: reload_q[7:0]  <= wdata_i;
          A_CTRL:   ctrl_q         <= ctrl_t'(wdata_i & 8'hFB);
          default: ;
        endcase
      end
      if (!en && cnt_wr) begin
        if (addr_i == A_CNT_HI) count_q[15:8] <= wdata_i;
        else                    count_q[7:0]  <= wdata_i;
      end else if (step) begin
        count_q <= timeout ? 16'h0001 : count_q + 16'd1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= timeout;
      if (!en)          out_q <= pol;
      else if (timeout) out_q <= ~out_q;
    end
  end

  always_comb begin
    unique case (addr_i)
      A_CNT_HI: rdata_o = count_q[15:8];
      A_CNT_LO: rdata_o = count_q[7:0];
      A_RLD_HI: rdata_o = reload_q[15:8];
      A_RLD_LO: rdata_o = reload_q[7:0];
      A_CTRL:   rdata_o = ctrl_q;
      default:  rdata_o = '0;
    endcase
  end

  assign tmr_out_o = out_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/mm_timer_chk.sv
module mm_timer_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        pol_i,
  input logic        edge_mode_i,
  input logic        cnt_wr_i,
  input logic [15:0] count_i,
  input logic        tmr_out_i,
  input logic        irq_i
);
  // R5
  irq_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> count_i == 16'd1);

  // R7
  irq_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> tmr_out_i != $past(tmr_out_i));

  // R11
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !cnt_wr_i) |=> $stable(count_i));

  // R11
  idle_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !irq_i);

  // R6
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> tmr_out_i == $past(pol_i));

  // R8
  edge_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_mode_i |=> (count_i == $past(count_i) || count_i == $past(count_i) + 16'd1
                     || count_i == 16'd1));
endmodule

bind mm_timer mm_timer_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en),
  .pol_i       (pol),
  .edge_mode_i (edge_mode),
  .cnt_wr_i    (cnt_wr),
  .count_i     (count_q),
  .tmr_out_i   (tmr_out_o),
  .irq_i       (irq_o)
);

// File: tb/mm_timer_tb.sv
module mm_timer_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = '0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       pin_i = 1'b0;
  logic       cmp_i = 1'b0;
  logic       tmr_out_o;
  logic       irq_o;

  int n_chk = 0;
  int n_fail = 0;
  int irq_seen = 0;

  always #2.5 clk_i = ~clk_i;

  mm_timer u_dut (.*);

  always @(negedge clk_i) if (irq_o) irq_seen++;

  // {start, reload, psel, pol, first_cycles, period_cycles}
  localparam int NV = 6;
  localparam logic [67:0] VECS [NV] = '{
    {16'd1,  16'd5,  3'd0, 1'b0, 16'd5,   16'd5},
    {16'd1,  16'd3,  3'd2, 1'b1, 16'd12,  16'd12},
    {16'd4,  16'd10, 3'd1, 1'b0, 16'd14,  16'd20},
    {16'd1,  16'd2,  3'd3, 1'b1, 16'd16,  16'd16},
    {16'd1,  16'd2,  3'd7, 1'b0, 16'd256, 16'd256},
    {16'd10, 16'd10, 3'd0, 1'b1, 16'd1,   16'd10}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr_i = a;
    #0.5 d = rdata_o;
  endtask

  task automatic pulse(input bit on_cmp);
    @(negedge clk_i);
    if (on_cmp) cmp_i = 1'b1; else pin_i = 1'b1;
    repeat (2) @(negedge clk_i);
    if (on_cmp) cmp_i = 1'b0; else pin_i = 1'b0;
    repeat (1) @(negedge clk_i);
  endtask

  task automatic setup(input logic [7:0] ctl, input logic [15:0] cnt, input logic [15:0] rld);
    wr(3'd4, ctl & 8'h7F);
    wr(3'd0, cnt[15:8]);
    wr(3'd1, cnt[7:0]);
    wr(3'd2, rld[15:8]);
    wr(3'd3, rld[7:0]);
    wr(3'd4, ctl);
  endtask

  task automatic wait_irq(output int cyc);
    cyc = 0;
    do begin
      @(posedge clk_i); @(negedge clk_i);
      cyc++;
    end while (!irq_o && cyc < 2000);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d, d2;
    int cyc, base;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    rd(3'd0, d); check("R1 count hi", d, 8'h00);
    rd(3'd1, d); check("R1 count lo", d, 8'h01);
    rd(3'd2, d); check("R1 reload hi", d, 8'hFF);
    rd(3'd3, d); check("R1 reload lo", d, 8'hFF);
    rd(3'd4, d); check("R1 ctrl", d, 8'h00);
    check("R1 out", tmr_out_o, 0);
    check("R1 irq", irq_o, 0);

    // R2 control readback, reserved bit and unmapped address
    wr(3'd4, 8'h7F);
    rd(3'd4, d); check("R2 ctrl readback", d, 8'h7B);
    rd(3'd6, d); check("R2 unmapped", d, 8'h00);

    // R4 R5 R6 R7 periodic vectors
    for (int i = 0; i < NV; i++) begin
      logic [15:0] st, rl, f, p;
      logic [2:0]  ps;
      logic        pl;
      {st, rl, ps, pl, f, p} = VECS[i];
      setup({1'b1, pl, ps, 1'b0, 2'b00}, st, rl);
      check("R6 idle level", tmr_out_o, pl);
      wait_irq(cyc);
      check("R5 first period", cyc, f);
      check("R6 toggled", tmr_out_o, !pl);
      wait_irq(cyc);
      check("R4 steady period", cyc, p);
    end

    // R2 live count read
    setup(8'h80, 16'h0001, 16'hFFFF);
    repeat (10) @(negedge clk_i);
    rd(3'd1, d); check("R2 live count", d, 8'h0B);

    // R3 count write ignored while running
    setup(8'hB8, 16'h0001, 16'hFFFF);
    wr(3'd0, 8'hAB);
    rd(3'd0, d); check("R3 hi ignored", d, 8'h00);
    rd(3'd1, d); check("R3 lo ignored", d, 8'h01);

    // R11 disabled holds, no irq
    wr(3'd4, 8'h00);
    base = irq_seen;
    rd(3'd1, d);
    repeat (20) @(negedge clk_i);
    rd(3'd1, d2); check("R11 count held", d2, d);
    check("R11 no irq", irq_seen - base, 0);

    // R6 idle level follows polarity
    wr(3'd4, 8'h40);
    @(negedge clk_i);
    check("R6 idle pol1", tmr_out_o, 1);

    // R8 R10 pin rising edges at quarter rate, comparator ignored
    setup(8'h81, 16'h0000, 16'hFFFF);
    for (int k = 0; k < 2; k++) pulse(1'b1);
    for (int k = 0; k < 3; k++) pulse(1'b0);
    repeat (6) @(negedge clk_i);
    rd(3'd1, d); check("R8 R10 pin rising", d, 8'h03);

    // R8 falling edges
    setup(8'hC1, 16'h0000, 16'hFFFF);
    for (int k = 0; k < 4; k++) pulse(1'b0);
    repeat (6) @(negedge clk_i);
    rd(3'd1, d); check("R8 pin falling", d, 8'h04);

    // R9 comparator edges, pin ignored
    setup(8'h82, 16'h0000, 16'hFFFF);
    for (int k = 0; k < 3; k++) pulse(1'b0);
    for (int k = 0; k < 4; k++) pulse(1'b1);
    repeat (6) @(negedge clk_i);
    rd(3'd1, d); check("R9 cmp rising", d, 8'h04);

    // R7 R5 time-out in edge mode
    setup(8'h81, 16'h0001, 16'h0003);
    base = irq_seen;
    for (int k = 0; k < 3; k++) pulse(1'b0);
    repeat (6) @(negedge clk_i);
    check("R7 single irq", irq_seen - base, 1);
    check("R7 out toggled", tmr_out_o, 1);
    rd(3'd1, d); check("R5 restart at 1", d, 8'h01);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule